// File: doc/BRIEF.md
# Root Clock Divider Tree

This block turns one root clock into three clock-enable strobes, one each for the CPU, AHB and APB domains. A two-bit select says which oscillator drives the root: crystal, PLL or fast RC. The block uses that select to interpret the per-domain divider fields. On the PLL path, a fixed high-speed prescaler of 3 sits in front of the CPU and AHB dividers. A force bit gives the CPU domain a ratio of 4, which the prescaled chain cannot reach. On the two slow paths, the prescaler is 1 and the dividers take powers of two.

Each domain reports the ratio it is currently running at. A new setting is first checked and captured in a shadow stage. It is applied only at the end of the domain's current period, so no period is ever cut short or stretched. An illegal setting is not applied. Instead it raises a sticky error flag, and the last legal ratio stays in force.

Top module: `clk_root_div_tree`

## Requirements
- R1: After reset, `cpu_ratio`, `ahb_ratio` and `apb_ratio` read 1, `cfg_err` and `src_bad` are low, and from the first clock edge after reset release all three enables stay high every cycle.
- R2: With select 0 (crystal) or 2 (fast RC), `cpu_ratio` becomes `cpu_div`+1 and `ahb_ratio` becomes `ahb_div`+1. The legal field values are 0, 1, 3, 7, 15 and 31.
- R3: With select 1 (PLL), the legal `cpu_div` values are 0, 1 and 3, giving `cpu_ratio` 3, 6 and 12.
- R4: With select 1 and `cpu_div` = 0, a high `hs_force4` makes `cpu_ratio` 4. With any other `cpu_div` value, or on a slow source, `hs_force4` has no effect on the ratio.
- R5: With select 1, the legal `ahb_div` values are 3, 7 and 15, giving `ahb_ratio` 12, 24 and 48.
- R6: `apb_div` values 0, 1 and 3 give `apb_ratio` 1, 2 and 4. `apb_en` pulses once every `apb_ratio` pulses of `ahb_en`, and only in a cycle where `ahb_en` is also high.
- R7: Each enable is a one-cycle pulse. The spacing between consecutive pulses, in root cycles, equals the ratio that was in force before the pulse. For APB this spacing is `ahb_ratio` × `apb_ratio`. A ratio of 1 keeps the enable high every cycle.
- R8: An illegal divider value sets `cfg_err`, which stays set until reset. The affected domain keeps its previous ratio. Examples of illegal values: PLL `cpu_div` 2, PLL `ahb_div` 0, `apb_div` 2, slow `cpu_div` 5.
- R9: Select value 3 drives `src_bad` high one cycle after it appears and sets `cfg_err`. `cpu_ratio` and `ahb_ratio` keep their previous values. `src_bad` falls again once a legal select is applied.
- R10: A ratio read-back changes only in a cycle where that domain's enable is high. A setting changed in the middle of a period first takes effect at the end of that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Root clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Root source: 0 crystal, 1 PLL, 2 fast RC, 3 invalid |
| cpu_div | input | CF_W | CPU divider field |
| ahb_div | input | AF_W | AHB divider field |
| apb_div | input | PF_W | APB divider field, relative to AHB |
| hs_force4 | input | 1 | Force CPU ratio 4 on the PLL path |
| cpu_en | output | 1 | CPU clock-enable pulse |
| ahb_en | output | 1 | AHB clock-enable pulse |
| apb_en | output | 1 | APB clock-enable pulse |
| cpu_ratio | output | RW | CPU ratio in force |
| ahb_ratio | output | RW | AHB ratio in force |
| apb_ratio | output | PW | APB ratio relative to AHB |
| src_bad | output | 1 | Select input holds the invalid code |
| cfg_err | output | 1 | Sticky illegal-setting flag |

## Verification
The bench targets several specific failure modes. The first is the force bit leaking into cases where it must be ignored: a faulty design would report 4 for PLL field 1 or for a crystal source. The second is the prescaler being applied to the wrong path, which shows up as ratios that are three times too large or too small. The third is a setting change in mid-period: a design that reloads immediately would produce one short gap, seen as 3 instead of 12. The remaining cases are illegal fields and the invalid select. A faulty design would either adopt the bad ratio, lose the error flag on a later legal write, or let the APB strobe drift away from the AHB strobe.

// File: rtl/clk_tree_pkg.sv
`timescale 1ns/1ps
package clk_tree_pkg;
  localparam logic [1:0] SRC_XTAL = 2'd0;
  localparam logic [1:0] SRC_PLL  = 2'd1;
  localparam logic [1:0] SRC_RCF  = 2'd2;
  localparam logic [1:0] SRC_BAD  = 2'd3;

  // Width needed to hold the largest ratio of any domain.
  function automatic int ratio_width(input int cf_w, input int af_w, input int hs_pre);
    int mx;
    mx = 2 ** cf_w;
    if (2 ** af_w > mx) mx = 2 ** af_w;
    if (hs_pre * 16 > mx) mx = hs_pre * 16;
    return $clog2(mx + 1);
  endfunction

  // True when v is of the form 2^k - 1.
  function automatic logic all_ones_low(input int v);
    return (v & (v + 1)) == 0;
  endfunction
endpackage

// File: rtl/ckt_cfg_decode.sv
`timescale 1ns/1ps
module ckt_cfg_decode
  import clk_tree_pkg::*;
#(
  parameter int CF_W        = 5,
  parameter int AF_W        = 5,
  parameter int PF_W        = 2,
  parameter int HS_PRE      = 3,
  parameter int FORCE_RATIO = 4,
  parameter int RW          = 6,
  parameter int PW          = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      src_sel,
  input  logic [CF_W-1:0] cpu_div,
  input  logic [AF_W-1:0] ahb_div,
  input  logic [PF_W-1:0] apb_div,
  input  logic            hs_force4,
  output logic [RW-1:0]   cpu_nxt,
  output logic [RW-1:0]   ahb_nxt,
  output logic [PW-1:0]   apb_nxt,
  output logic            src_bad,
  output logic            cfg_err
);
  localparam int APB_MAXF = 3;

  logic          pll_sel, slow_sel;
  logic          cpu_ok, ahb_ok, apb_ok;
  logic [RW-1:0] cpu_cand, ahb_cand;
  logic [PW-1:0] apb_cand;
  int            cf_i, af_i, pf_i;

  always_comb begin
    cf_i     = int'(cpu_div);
    af_i     = int'(ahb_div);
    pf_i     = int'(apb_div);
    pll_sel  = (src_sel == SRC_PLL);
    slow_sel = (src_sel == SRC_XTAL) || (src_sel == SRC_RCF);

    if (pll_sel) begin
      cpu_ok = (cf_i == 0) || (cf_i == 1) || (cf_i == 3);
      ahb_ok = (af_i == 3) || (af_i == 7) || (af_i == 15);
      if (hs_force4 && cf_i == 0) cpu_cand = RW'(FORCE_RATIO);
      else                        cpu_cand = RW'(HS_PRE * (cf_i + 1));
      ahb_cand = RW'(HS_PRE * (af_i + 1));
    end else begin
      cpu_ok   = slow_sel && all_ones_low(cf_i);
      ahb_ok   = slow_sel && all_ones_low(af_i);
      cpu_cand = RW'(cf_i + 1);
      ahb_cand = RW'(af_i + 1);
    end

    apb_ok   = all_ones_low(pf_i) && (pf_i <= APB_MAXF);
    apb_cand = PW'(pf_i + 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_nxt <= RW'(1);
      ahb_nxt <= RW'(1);
      apb_nxt <= PW'(1);
      src_bad <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      src_bad <= (src_sel == SRC_BAD);
      if (cpu_ok) cpu_nxt <= cpu_cand;
      if (ahb_ok) ahb_nxt <= ahb_cand;
      if (apb_ok) apb_nxt <= apb_cand;
      if (!cpu_ok || !ahb_ok || !apb_ok) cfg_err <= 1'b1;
    end
  end
endmodule

// File: rtl/ckt_div_unit.sv
`timescale 1ns/1ps
module ckt_div_unit #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] ratio_nxt,
  output logic         en,
  output logic         wrap,
  output logic [W-1:0] ratio
);
  logic [W-1:0] cnt;

  assign wrap = step && (cnt == ratio - W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ratio <= W'(1);
      en    <= 1'b0;
    end else begin
      en <= wrap;
      if (wrap) begin
        cnt   <= '0;
        ratio <= ratio_nxt;
      end else if (step) begin
        cnt <= cnt + W'(1);
      end
    end
  end
endmodule

// File: rtl/clk_root_div_tree.sv
`timescale 1ns/1ps
module clk_root_div_tree
  import clk_tree_pkg::*;
#(
  parameter  int CF_W        = 5,
  parameter  int AF_W        = 5,
  parameter  int PF_W        = 2,
  parameter  int HS_PRE      = 3,
  parameter  int FORCE_RATIO = 4,
  localparam int RW          = ratio_width(CF_W, AF_W, HS_PRE),
  localparam int PW          = $clog2((2 ** PF_W) + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      src_sel,
  input  logic [CF_W-1:0] cpu_div,
  input  logic [AF_W-1:0] ahb_div,
  input  logic [PF_W-1:0] apb_div,
  input  logic            hs_force4,
  output logic            cpu_en,
  output logic            ahb_en,
  output logic            apb_en,
  output logic [RW-1:0]   cpu_ratio,
  output logic [RW-1:0]   ahb_ratio,
  output logic [PW-1:0]   apb_ratio,
  output logic            src_bad,
  output logic            cfg_err
);
  logic [RW-1:0] cpu_nxt, ahb_nxt;
  logic [PW-1:0] apb_nxt;
  logic          cpu_wrap, ahb_wrap, apb_wrap;

  ckt_cfg_decode #(
    .CF_W(CF_W), .AF_W(AF_W), .PF_W(PF_W), .HS_PRE(HS_PRE),
    .FORCE_RATIO(FORCE_RATIO), .RW(RW), .PW(PW)
  ) cfg_u (
    .clk(clk), .rst(rst), .src_sel(src_sel), .cpu_div(cpu_div),
    .ahb_div(ahb_div), .apb_div(apb_div), .hs_force4(hs_force4),
    .cpu_nxt(cpu_nxt), .ahb_nxt(ahb_nxt), .apb_nxt(apb_nxt),
    .src_bad(src_bad), .cfg_err(cfg_err)
  );

  ckt_div_unit #(.W(RW)) cpu_u (
    .clk(clk), .rst(rst), .step(1'b1), .ratio_nxt(cpu_nxt),
    .en(cpu_en), .wrap(cpu_wrap), .ratio(cpu_ratio)
  );

  ckt_div_unit #(.W(RW)) ahb_u (
    .clk(clk), .rst(rst), .step(1'b1), .ratio_nxt(ahb_nxt),
    .en(ahb_en), .wrap(ahb_wrap), .ratio(ahb_ratio)
  );

  // APB counts AHB boundaries, so its pulses always land on AHB pulses.
  ckt_div_unit #(.W(PW)) apb_u (
    .clk(clk), .rst(rst), .step(ahb_wrap), .ratio_nxt(apb_nxt),
    .en(apb_en), .wrap(apb_wrap), .ratio(apb_ratio)
  );
endmodule

// File: rtl/ckt_sva.sv
`timescale 1ns/1ps
module ckt_sva #(
  parameter int RW = 6,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_en,
  input logic          ahb_en,
  input logic          apb_en,
  input logic [RW-1:0] cpu_ratio,
  input logic [RW-1:0] ahb_ratio,
  input logic [PW-1:0] apb_ratio,
  input logic          cfg_err
);
  logic [7:0] cpu_gap, ahb_gap;
  logic       cpu_seen, ahb_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_gap <= '0; ahb_gap <= '0; cpu_seen <= 1'b0; ahb_seen <= 1'b0;
    end else begin
      if (cpu_en) begin cpu_gap <= 8'd1; cpu_seen <= 1'b1; end
      else if (cpu_gap != 8'hff) cpu_gap <= cpu_gap + 8'd1;
      if (ahb_en) begin ahb_gap <= 8'd1; ahb_seen <= 1'b1; end
      else if (ahb_gap != 8'hff) ahb_gap <= ahb_gap + 8'd1;
    end
  end

  AST_CPU_GAP: assert property (@(posedge clk) disable iff (rst)
    (cpu_en && cpu_seen) |-> (cpu_gap == 8'($past(cpu_ratio)))); // R7
  AST_AHB_GAP: assert property (@(posedge clk) disable iff (rst)
    (ahb_en && ahb_seen) |-> (ahb_gap == 8'($past(ahb_ratio)))); // R7
  AST_CPU_RB_EDGE: assert property (@(posedge clk) disable iff (rst)
    !$stable(cpu_ratio) |-> cpu_en); // R10
  AST_AHB_RB_EDGE: assert property (@(posedge clk) disable iff (rst)
    !$stable(ahb_ratio) |-> ahb_en); // R10
  AST_APB_RB_EDGE: assert property (@(posedge clk) disable iff (rst)
    !$stable(apb_ratio) |-> apb_en); // R10
  AST_APB_ON_AHB: assert property (@(posedge clk) disable iff (rst)
    apb_en |-> ahb_en); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err); // R8
  AST_CPU_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (cpu_ratio inside {1, 2, 3, 4, 6, 8, 12, 16, 32})); // R3
endmodule

bind clk_root_div_tree ckt_sva #(.RW(RW), .PW(PW)) sva_u (
  .clk(clk), .rst(rst), .cpu_en(cpu_en), .ahb_en(ahb_en), .apb_en(apb_en),
  .cpu_ratio(cpu_ratio), .ahb_ratio(ahb_ratio), .apb_ratio(apb_ratio),
  .cfg_err(cfg_err)
);

// File: tb/clk_root_div_tree_tb_top.sv
`timescale 1ns/1ps
module clk_root_div_tree_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] src_sel = 2'd0;
  logic [4:0] cpu_div = '0;
  logic [4:0] ahb_div = '0;
  logic [1:0] apb_div = '0;
  logic       hs_force4 = 1'b0;
  logic       cpu_en, ahb_en, apb_en, src_bad, cfg_err;
  logic [5:0] cpu_ratio, ahb_ratio;
  logic [2:0] apb_ratio;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  clk_root_div_tree dut_i (
    .clk(clk), .rst(rst), .src_sel(src_sel), .cpu_div(cpu_div),
    .ahb_div(ahb_div), .apb_div(apb_div), .hs_force4(hs_force4),
    .cpu_en(cpu_en), .ahb_en(ahb_en), .apb_en(apb_en),
    .cpu_ratio(cpu_ratio), .ahb_ratio(ahb_ratio), .apb_ratio(apb_ratio),
    .src_bad(src_bad), .cfg_err(cfg_err)
  );

  typedef struct packed {
    logic [1:0] src;
    logic [4:0] cf;
    logic [4:0] af;
    logic [1:0] pf;
    logic       frc;
    logic [5:0] ec;
    logic [5:0] ea;
    logic [2:0] ep;
  } vec_t;

  // R2 R3 R4 R5 R6 vectors: select, fields, force, expected ratios
  localparam vec_t VECS [12] = '{
    '{2'd0, 5'd0,  5'd0,  2'd0, 1'b0, 6'd1,  6'd1,  3'd1},
    '{2'd0, 5'd1,  5'd3,  2'd1, 1'b0, 6'd2,  6'd4,  3'd2},
    '{2'd2, 5'd31, 5'd31, 2'd3, 1'b0, 6'd32, 6'd32, 3'd4},
    '{2'd2, 5'd7,  5'd15, 2'd0, 1'b0, 6'd8,  6'd16, 3'd1},
    '{2'd1, 5'd0,  5'd3,  2'd0, 1'b0, 6'd3,  6'd12, 3'd1},
    '{2'd1, 5'd1,  5'd7,  2'd1, 1'b0, 6'd6,  6'd24, 3'd2},
    '{2'd1, 5'd3,  5'd15, 2'd3, 1'b0, 6'd12, 6'd48, 3'd4},
    '{2'd1, 5'd0,  5'd3,  2'd1, 1'b1, 6'd4,  6'd12, 3'd2},
    '{2'd1, 5'd1,  5'd3,  2'd0, 1'b1, 6'd6,  6'd12, 3'd1},
    '{2'd0, 5'd0,  5'd1,  2'd0, 1'b1, 6'd1,  6'd2,  3'd1},
    '{2'd2, 5'd3,  5'd0,  2'd3, 1'b1, 6'd4,  6'd1,  3'd4},
    '{2'd0, 5'd15, 5'd7,  2'd1, 1'b0, 6'd16, 6'd8,  3'd2}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    src_sel = 2'd0; cpu_div = '0; ahb_div = '0; apb_div = '0; hs_force4 = 1'b0;
    cycles(3);
    rst = 1'b0;
  endtask

  task automatic apply(input logic [1:0] s, input logic [4:0] c, input logic [4:0] a,
                       input logic [1:0] p, input logic f);
    src_sel = s; cpu_div = c; ahb_div = a; apb_div = p; hs_force4 = f;
  endtask

  function automatic logic en_of(input int w);
    return (w == 0) ? cpu_en : (w == 1) ? ahb_en : apb_en;
  endfunction

  // Root cycles between two consecutive pulses of the chosen enable.
  task automatic gap_of(input int w, output int gap);
    int k;
    k = 0;
    @(negedge clk);
    while (!en_of(w) && k < 600) begin @(negedge clk); k++; end
    gap = 0;
    do begin @(negedge clk); gap++; end while (!en_of(w) && gap < 600);
  endtask

  initial begin
    #(8ns * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int g, n, ones;
    // R1 reset state
    do_reset();
    @(negedge clk);
    check("R1 cpu_ratio", cpu_ratio, 1);
    check("R1 ahb_ratio", ahb_ratio, 1);
    check("R1 apb_ratio", apb_ratio, 1);
    check("R1 cfg_err", cfg_err, 0);
    check("R1 src_bad", src_bad, 0);
    ones = 0;
    for (int i = 0; i < 4; i++) begin
      ones += (cpu_en && ahb_en && apb_en) ? 1 : 0;
      @(negedge clk);
    end
    check("R1 enables held high", ones, 4);

    // Table walk: R2 R3 R4 R5 R6 R7
    foreach (VECS[i]) begin
      apply(VECS[i].src, VECS[i].cf, VECS[i].af, VECS[i].pf, VECS[i].frc);
      cycles(300);
      check($sformatf("R2 R3 R4 cpu_ratio vec %0d", i), cpu_ratio, VECS[i].ec);
      check($sformatf("R2 R5 ahb_ratio vec %0d", i), ahb_ratio, VECS[i].ea);
      check($sformatf("R6 apb_ratio vec %0d", i), apb_ratio, VECS[i].ep);
      check($sformatf("R8 no error vec %0d", i), cfg_err, 0);
      gap_of(0, g); check($sformatf("R7 cpu gap vec %0d", i), g, VECS[i].ec);
      gap_of(1, g); check($sformatf("R7 ahb gap vec %0d", i), g, VECS[i].ea);
      gap_of(2, g); check($sformatf("R6 R7 apb gap vec %0d", i), g,
                          int'(VECS[i].ea) * int'(VECS[i].ep));
    end

    // R10 mid-period change keeps the running period
    do_reset();
    apply(2'd1, 5'd3, 5'd3, 2'd0, 1'b0);
    cycles(300);
    @(negedge clk);
    while (!cpu_en) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 2) cpu_div = 5'd0;
      if (n == 5) check("R10 ratio held mid-period", cpu_ratio, 12);
    end while (!cpu_en && n < 100);
    check("R10 running period completed", n, 12);
    check("R10 new ratio at boundary", cpu_ratio, 3);
    gap_of(0, g); check("R10 next gap uses new ratio", g, 3);

    // R8 illegal slow CPU field, then sticky flag
    do_reset();
    apply(2'd0, 5'd1, 5'd0, 2'd0, 1'b0);
    cycles(100);
    check("R8 legal start", cpu_ratio, 2);
    cpu_div = 5'd5;
    cycles(100);
    check("R8 slow cpu kept", cpu_ratio, 2);
    check("R8 error raised", cfg_err, 1);
    cpu_div = 5'd3;
    cycles(100);
    check("R8 later legal applied", cpu_ratio, 4);
    check("R8 error sticky", cfg_err, 1);

    // R8 illegal PLL CPU field 2
    do_reset();
    apply(2'd1, 5'd1, 5'd7, 2'd1, 1'b0);
    cycles(200);
    cpu_div = 5'd2;
    cycles(200);
    check("R8 pll cpu kept", cpu_ratio, 6);
    check("R8 pll cpu error", cfg_err, 1);

    // R8 illegal PLL AHB field 0
    do_reset();
    apply(2'd1, 5'd0, 5'd3, 2'd0, 1'b0);
    cycles(100);
    ahb_div = 5'd0;
    cycles(100);
    check("R8 pll ahb kept", ahb_ratio, 12);
    check("R8 pll ahb error", cfg_err, 1);

    // R8 illegal APB field 2
    do_reset();
    apply(2'd0, 5'd0, 5'd1, 2'd1, 1'b0);
    cycles(50);
    apb_div = 2'd2;
    cycles(50);
    check("R8 apb kept", apb_ratio, 2);
    check("R8 apb error", cfg_err, 1);

    // R9 invalid source select
    do_reset();
    apply(2'd2, 5'd3, 5'd1, 2'd0, 1'b0);
    cycles(100);
    src_sel = 2'd3;
    cycles(2);
    check("R9 src_bad raised", src_bad, 1);
    cycles(100);
    check("R9 cpu kept", cpu_ratio, 4);
    check("R9 ahb kept", ahb_ratio, 2);
    check("R9 error raised", cfg_err, 1);
    src_sel = 2'd0;
    cycles(2);
    check("R9 src_bad cleared", src_bad, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule